// File: doc/BRIEF.md
# ARINC 429 Word Receiver

This block turns a pair of digital level-detect lines, one pulsing for a logic one and the other for a logic zero, into complete 32-bit ARINC 429 words. The line is sampled at ten samples per bit. A glitch filter, a framing state machine and a word-gap timer recover the bits and throw away any partial word that breaks the return-to-zero rules. A finished word can be filtered on its label bits 9 and 10. Its bit-32 position is replaced by a parity-check result before the word is held for the host.

The host sees an active-low ready flag and reads the held word as two 16-bit halves. It drives a select level and pulses a one-cycle read enable for each half. The halves may be read in either order. The flag returns high once both halves of the current word have been read. A newer accepted word replaces an unread one without warning.

Top module: `a429_word_rx`

## Requirements
- R1: With `slow_sel` low the lines are sampled on every clock. With `slow_sel` high they are sampled once every 8 clocks. A word made of 10-sample bits (5 data samples, 5 null samples) is received in both modes.
- R2: A line level (one: `ones_in`=1,`zeros_in`=0; zero: `ones_in`=0,`zeros_in`=1; null: both 0; invalid: both 1) is taken only after 3 consecutive samples of it. A shorter pulse has no effect on the received word.
- R3: The first data bit received is ARINC bit 1. A word is complete when the data phase of the 32nd bit is followed by a null.
- R4: A data level followed by the other data level with no null between them, or an invalid level, discards the partial word. No word is delivered from it.
- R5: A word is only started after at least 40 consecutive null samples (4 bit times). Data that follows a shorter null is ignored until such a gap has occurred.
- R6: With `dec_en` high, a complete word is accepted only if ARINC bit 9 equals `match9` and bit 10 equals `match10`. A rejected word leaves the flag and the held word unchanged. With `dec_en` low every complete word is accepted.
- R7: The held bit-32 position is 0 when the number of ones in all 32 received bits is odd, and 1 when it is even.
- R8: On an accepted word `ready_n` goes low. It stays low until both halves have been read in either order, and reading one half keeps it low.
- R9: A word accepted before both halves of the previous one were read replaces it and restarts the read tracking.
- R10: With `rd_sel` high, `rd_data[15:0]` is ARINC bits 29..14. With `rd_sel` low, `rd_data[15:11]` is bits 13..9, bit 10 is ARINC bit 31, bit 9 is ARINC bit 30, bit 8 is the parity result, and bits 7..0 are ARINC bits 1..8.
- R11: While `rst_n` is low at a clock edge, `ready_n` is forced high and the held word is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ones_in | input | 1 | Level-detect line for a logic one |
| zeros_in | input | 1 | Level-detect line for a logic zero |
| slow_sel | input | 1 | 1 selects one sample per 8 clocks |
| dec_en | input | 1 | Enables the label-bit filter |
| match9 | input | 1 | Required value of ARINC bit 9 |
| match10 | input | 1 | Required value of ARINC bit 10 |
| rd_en | input | 1 | One-cycle read strobe for a half |
| rd_sel | input | 1 | 0 = first half, 1 = second half |
| ready_n | output | 1 | Low while an unread word is held |
| rd_data | output | 16 | Selected half of the held word |

## Verification
The bench reads the halves in both orders and reads only one half before a new word arrives. A design that cleared the flag after one read, or kept the stale read marks across an overwrite, would show a wrong `ready_n`. Words with a missing null, an invalid level, or too short a gap before them must never raise the flag. Two-sample glitches inside null phases must not corrupt a word, so a filter that was too short or a framer that was too eager would deliver a false word or lose a real one. Words with even and odd ones counts, a label match and a label mismatch, and the slow sample clock check the parity position, the label filter and the sample divider.

// File: rtl/a429_pkg.sv
// Shared types for the ARINC 429 word receiver.
// Assumes line levels are encoded as {zeros, ones}.
package a429_pkg;
    typedef enum logic [1:0] {
        LV_NULL = 2'b00,
        LV_ONE  = 2'b01,
        LV_ZERO = 2'b10,
        LV_BAD  = 2'b11
    } lvl_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ARMED,
        FR_DATA,
        FR_NULL
    } fr_state_t;
endpackage

// File: rtl/a429_sample_tick.sv
// Sample-enable generator: fires on every clock in fast mode and once per
// DIV clocks in slow mode. Assumes slow_sel changes only between words.
module a429_sample_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Free-running divider counter, wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = slow_sel ? (cnt == '0) : 1'b1;
endmodule

// File: rtl/a429_level_filter.sv
// Line-level glitch filter: decodes the two detect lines into a level and
// accepts a new level only after RUN consecutive matching samples.
// Emits a one-cycle chg pulse whenever the accepted level changes.
module a429_level_filter
    import a429_pkg::*;
#(
    parameter int RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ones_in,
    input  logic zeros_in,
    output lvl_t level,
    output logic chg
);
    localparam int RW = $clog2(RUN + 1);

    lvl_t          raw;
    lvl_t          prev;
    logic [RW-1:0] run;
    logic [RW-1:0] run_nx;

    // Decode the raw sample and the length of the current run.
    always_comb begin
        raw = lvl_t'({zeros_in, ones_in});
        if (raw == prev)
            run_nx = (run == RW'(RUN)) ? run : run + 1'b1;
        else
            run_nx = RW'(1);
    end

    // Track runs and commit a level once it has lasted RUN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= LV_NULL;
            run   <= '0;
            level <= LV_NULL;
            chg   <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (tick) begin
                prev <= raw;
                run  <= run_nx;
                if (run_nx >= RW'(RUN) && raw != level) begin
                    level <= raw;
                    chg   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/a429_word_framer.sv
// Word framer: assembles NBITS return-to-zero bits into a word, enforces a
// null between bits and a gap of GAP null samples before a word, discards
// on errors, replaces the top bit by the parity check and applies the
// label filter. Bit 1 of the line lands in rx[0].
module a429_word_framer
    import a429_pkg::*;
#(
    parameter int NBITS = 32,
    parameter int GAP   = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  lvl_t             level,
    input  logic             chg,
    input  logic             dec_en,
    input  logic             match9,
    input  logic             match10,
    output logic [NBITS-1:0] word,
    output logic             word_done,
    output logic             word_ok
);
    localparam int CNW   = $clog2(NBITS + 1);
    localparam int IW    = $clog2(NBITS);
    localparam int GW    = $clog2(GAP + 1);
    localparam int LBL_A = 8;
    localparam int LBL_B = 9;

    fr_state_t        st;
    logic [CNW-1:0]   cnt;
    logic [NBITS-1:0] rx;
    logic [GW-1:0]    gap;
    logic             gap_ok;
    logic             is_one;
    logic             accept;
    logic             par;

    // Derived conditions used by the state machine.
    always_comb begin
        gap_ok = (gap >= GW'(GAP));
        is_one = (level == LV_ONE);
        accept = !dec_en || (rx[LBL_A] == match9 && rx[LBL_B] == match10);
        par    = ~(^rx);
    end

    // Gap timer, bit collection and end-of-word decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= FR_IDLE;
            cnt       <= '0;
            rx        <= '0;
            gap       <= '0;
            word      <= '0;
            word_done <= 1'b0;
            word_ok   <= 1'b0;
        end else begin
            word_done <= 1'b0;
            word_ok   <= 1'b0;
            if (tick) begin
                if (level != LV_NULL)
                    gap <= '0;
                else if (!gap_ok)
                    gap <= gap + 1'b1;
            end
            if (chg) begin
                if (level == LV_BAD) begin
                    st <= FR_IDLE;
                end else begin
                    case (st)
                        FR_ARMED: begin
                            if (level != LV_NULL) begin
                                rx[0] <= is_one;
                                cnt   <= CNW'(1);
                                st    <= FR_DATA;
                            end
                        end
                        FR_DATA: begin
                            if (level == LV_NULL) begin
                                if (cnt == CNW'(NBITS)) begin
                                    word_done <= 1'b1;
                                    word_ok   <= accept;
                                    word      <= {par, rx[NBITS-2:0]};
                                    st        <= FR_IDLE;
                                end else begin
                                    st <= FR_NULL;
                                end
                            end else begin
                                st <= FR_IDLE;
                            end
                        end
                        FR_NULL: begin
                            if (level != LV_NULL) begin
                                rx[cnt[IW-1:0]] <= is_one;
                                cnt             <= cnt + 1'b1;
                                st              <= FR_DATA;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (gap_ok && (st == FR_IDLE || st == FR_NULL)) begin
                st <= FR_ARMED;
            end
        end
    end
endmodule

// File: rtl/a429_hold_port.sv
// Holding register and host read port: keeps the last accepted word,
// tracks which halves were read, drives the active-low ready flag and
// maps the selected half onto the 16-bit read bus.
module a429_hold_port #(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_ok,
    input  logic [NBITS-1:0] word,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic             ready_n,
    output logic [15:0]      rd_data
);
    localparam int LOW_LBL = 5;
    localparam int LOW_DAT = 8;

    logic [NBITS-1:0] held;
    logic             rd_lo;
    logic             rd_hi;
    logic             lo_nx;
    logic             hi_nx;
    logic [15:0]      half_lo;
    logic [15:0]      half_hi;

    // Read marks after the current strobe.
    always_comb begin
        lo_nx = rd_lo | ~rd_sel;
        hi_nx = rd_hi | rd_sel;
    end

    // Capture accepted words and clear the flag once both halves are read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= '0;
            rd_lo   <= 1'b0;
            rd_hi   <= 1'b0;
            ready_n <= 1'b1;
        end else if (word_ok) begin
            held    <= word;
            rd_lo   <= 1'b0;
            rd_hi   <= 1'b0;
            ready_n <= 1'b0;
        end else if (rd_en) begin
            rd_lo <= lo_nx;
            rd_hi <= hi_nx;
            if (lo_nx && hi_nx)
                ready_n <= 1'b1;
        end
    end

    assign half_hi = held[28:13];
    assign half_lo[10] = held[30];
    assign half_lo[9]  = held[29];
    assign half_lo[8]  = held[31];

    for (genvar k = 0; k < LOW_LBL; k++) begin : g_lbl
        assign half_lo[11 + k] = held[8 + k];
    end
    for (genvar k = 0; k < LOW_DAT; k++) begin : g_dat
        assign half_lo[7 - k] = held[k];
    end

    assign rd_data = rd_sel ? half_hi : half_lo;
endmodule

// File: rtl/a429_word_rx.sv
// ARINC 429 word receiver top: sample divider, level filter, word framer
// and host read port. Assumes the detect lines are already synchronous
// to clk and that the configuration pins are static during a word.
module a429_word_rx
    import a429_pkg::*;
#(
    parameter int NBITS    = 32,
    parameter int SAMP_DIV = 8,
    parameter int RUN      = 3,
    parameter int SPB      = 10,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ones_in,
    input  logic        zeros_in,
    input  logic        slow_sel,
    input  logic        dec_en,
    input  logic        match9,
    input  logic        match10,
    input  logic        rd_en,
    input  logic        rd_sel,
    output logic        ready_n,
    output logic [15:0] rd_data
);
    localparam int GAP = SPB * GAP_BITS;

    logic             tick;
    lvl_t             level;
    logic             lvl_chg;
    logic [NBITS-1:0] fr_word;
    logic             word_done;
    logic             word_ok;

    a429_sample_tick #(.DIV(SAMP_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_sel (slow_sel),
        .tick     (tick)
    );

    a429_level_filter #(.RUN(RUN)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ones_in  (ones_in),
        .zeros_in (zeros_in),
        .level    (level),
        .chg      (lvl_chg)
    );

    a429_word_framer #(.NBITS(NBITS), .GAP(GAP)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .level     (level),
        .chg       (lvl_chg),
        .dec_en    (dec_en),
        .match9    (match9),
        .match10   (match10),
        .word      (fr_word),
        .word_done (word_done),
        .word_ok   (word_ok)
    );

    a429_hold_port #(.NBITS(NBITS)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_ok (word_ok),
        .word    (fr_word),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .ready_n (ready_n),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/a429_word_rx_chk.sv
// Property checker for the word receiver, attached by bind.
module a429_word_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        slow_sel,
    input logic        tick,
    input logic        dec_en,
    input logic        match9,
    input logic        match10,
    input logic        word_done,
    input logic        word_ok,
    input logic [31:0] fr_word,
    input logic        rd_en,
    input logic        ready_n
);
    // R1
    slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_sel && tick) |=> (!tick || !slow_sel));

    // R8
    ready_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> $past(word_ok));

    // R8
    ready_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> $past(rd_en));

    // R6
    label_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && dec_en && (fr_word[8] != match9 || fr_word[9] != match10))
        |=> !$fell(ready_n));
endmodule

bind a429_word_rx a429_word_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_sel  (slow_sel),
    .tick      (tick),
    .dec_en    (dec_en),
    .match9    (match9),
    .match10   (match10),
    .word_done (word_done),
    .word_ok   (word_ok),
    .fr_word   (fr_word),
    .rd_en     (rd_en),
    .ready_n   (ready_n)
);

// File: tb/a429_word_rx_bench.sv
module a429_word_rx_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        ones_in = 1'b0, zeros_in = 1'b0;
    logic        slow_sel = 1'b0, dec_en = 1'b0, match9 = 1'b0, match10 = 1'b0;
    logic        rd_en = 1'b0, rd_sel = 1'b0;
    logic        ready_n;
    logic [15:0] rd_data;

    a429_word_rx u_a429_word_rx (
        .clk(clk), .rst_n(rst_n), .ones_in(ones_in), .zeros_in(zeros_in),
        .slow_sel(slow_sel), .dec_en(dec_en), .match9(match9), .match10(match10),
        .rd_en(rd_en), .rd_sel(rd_sel), .ready_n(ready_n), .rd_data(rd_data)
    );

    localparam logic [1:0] NUL = 2'b00, ONE = 2'b01, ZER = 2'b10, BADL = 2'b11;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mask_until = 0;
    bit cmp_on = 1'b0;
    int spc = 1;

    // behavioural reference state
    logic [31:0] m_word = '0;
    bit          m_lo = 1'b0, m_hi = 1'b0;
    logic        m_ready_n = 1'b1;

    function automatic logic [15:0] exp_half(logic [31:0] w, bit sel);
        logic [15:0] h;
        h = '0;
        if (sel) begin
            for (int b = 14; b <= 29; b++) h[b - 14] = w[b - 1];
        end else begin
            for (int b = 9; b <= 13; b++) h[b + 2] = w[b - 1];
            h[10] = w[30];
            h[9]  = w[29];
            h[8]  = w[31];
            for (int b = 1; b <= 8; b++) h[8 - b] = w[b - 1];
        end
        return h;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // per-clock comparison of the ready flag against the model, plus watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        #5;
        if (cmp_on && cyc > mask_until) begin
            checks++;
            if (ready_n !== m_ready_n) begin
                errors++;
                $display("FAIL R8 ready_n per-clock at cycle %0d: got %b expected %b",
                         cyc, ready_n, m_ready_n);
            end
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    task automatic line(input logic [1:0] lv, input int n);
        repeat (n * spc) begin
            @(negedge clk);
            {zeros_in, ones_in} = lv;
        end
    endtask

    task automatic model_word(input logic [31:0] w);
        mask_until = cyc + 4 * spc + 8;
        if (!dec_en || (w[8] == match9 && w[9] == match10)) begin
            m_word    = {~(^w), w[30:0]};
            m_lo      = 1'b0;
            m_hi      = 1'b0;
            m_ready_n = 1'b0;
        end
    endtask

    // one well-formed word; glitch=1 adds a 2-sample one pulse in each null
    task automatic send(input logic [31:0] w, input bit expect_ok, input bit glitch, input int gap);
        for (int i = 0; i < 32; i++) begin
            line(w[i] ? ONE : ZER, 5);
            if (i == 31 && expect_ok) model_word(w);
            if (glitch) begin
                line(NUL, 3); line(ONE, 2); line(NUL, 2);
            end else begin
                line(NUL, 5);
            end
        end
        line(NUL, gap);
    endtask

    // word with an error at bit eb: mode 0 = no null, mode 1 = invalid level
    task automatic send_err(input logic [31:0] w, input int eb, input bit mode);
        for (int i = 0; i < 32; i++) begin
            if (i == eb) begin
                if (mode) line(BADL, 5);
                else begin line(ONE, 5); line(ZER, 5); end
            end else begin
                line(w[i] ? ONE : ZER, 5);
            end
            line(NUL, 5);
        end
        line(NUL, 60);
    endtask

    task automatic rd(input bit sel, input string tag);
        logic [15:0] e;
        @(negedge clk);
        rd_sel = sel;
        rd_en  = 1'b1;
        mask_until = cyc + 3;
        @(posedge clk);
        #5;
        e = exp_half(m_word, sel);
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s rd_data sel=%0b: got %h expected %h", tag, sel, rd_data, e);
        end
        if (sel) m_hi = 1'b1; else m_lo = 1'b1;
        if (m_lo && m_hi) m_ready_n = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_ready(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (ready_n !== exp) begin
            errors++;
            $display("FAIL %s ready_n: got %b expected %b", tag, ready_n, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk_ready(1'b1, "R11 reset");
        rst_n = 1'b1;
        cmp_on = 1'b1;
        line(NUL, 60);

        // R3 R7 R10: basic word, first half then second half
        send(32'h8A5C3E17, 1'b1, 1'b0, 60);
        chk_ready(1'b0, "R8 after word");
        rd(1'b0, "R10 lo");
        chk_ready(1'b0, "R8 one half read");
        rd(1'b1, "R10 hi");
        chk_ready(1'b1, "R8 both read");

        // R7 other parity; R8 reverse order
        send(32'h8A5C3E16, 1'b1, 1'b0, 60);
        rd(1'b1, "R8 hi first");
        chk_ready(1'b0, "R8 hi only");
        rd(1'b0, "R7 lo parity");
        chk_ready(1'b1, "R8 reverse both");

        // R9 overwrite after partial read
        send(32'h12345678, 1'b1, 1'b0, 60);
        rd(1'b0, "R9 partial");
        send(32'hFEDC0BA9, 1'b1, 1'b0, 60);
        chk_ready(1'b0, "R9 after overwrite");
        rd(1'b0, "R9 new lo");
        chk_ready(1'b0, "R9 tracking restarted");
        rd(1'b1, "R9 new hi");

        // R6 label filter match and mismatch
        dec_en = 1'b1; match9 = 1'b1; match10 = 1'b0;
        send(32'h0F0F0155, 1'b1, 1'b0, 60);
        chk_ready(1'b0, "R6 match accepted");
        rd(1'b0, "R6 match lo");
        rd(1'b1, "R6 match hi");
        send(32'h0F0F0355, 1'b1, 1'b0, 60);
        chk_ready(1'b1, "R6 mismatch ignored");
        rd(1'b0, "R6 old word kept");
        dec_en = 1'b0;

        // R4 errors discard the word
        send_err(32'h13572468, 12, 1'b0);
        chk_ready(1'b1, "R4 no null");
        send_err(32'h24681357, 10, 1'b1);
        chk_ready(1'b1, "R4 invalid level");
        rd(1'b1, "R4 held unchanged");
        send(32'h5555AAAA, 1'b1, 1'b0, 60);
        chk_ready(1'b0, "R4 recovery");
        rd(1'b0, "R4 recovery lo");
        rd(1'b1, "R4 recovery hi");

        // R2 glitches in null phases
        send(32'hDEADBEEF, 1'b1, 1'b1, 60);
        chk_ready(1'b0, "R2 glitch word");
        rd(1'b1, "R2 hi");
        rd(1'b0, "R2 lo");

        // R5 short gap: next word ignored
        send(32'h3C3CC3C3, 1'b1, 1'b0, 15);
        send(32'h77771111, 1'b0, 1'b0, 60);
        chk_ready(1'b0, "R5 first kept");
        rd(1'b0, "R5 lo of first");
        rd(1'b1, "R5 hi of first");
        chk_ready(1'b1, "R5 short-gap word ignored");

        // R1 slow sampling
        @(negedge clk);
        slow_sel = 1'b1;
        spc = 8;
        mask_until = cyc + 4;
        line(NUL, 60);
        send(32'hA1B2C3D4, 1'b1, 1'b0, 60);
        chk_ready(1'b0, "R1 slow word");
        rd(1'b0, "R1 slow lo");
        rd(1'b1, "R1 slow hi");
        chk_ready(1'b1, "R1 slow both read");

        // R11 reset clears the flag and the held word
        send(32'h0BADF00D, 1'b1, 1'b0, 10);
        cmp_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_ready(1'b1, "R11 reset flag");
        m_word = '0;
        rd(1'b1, "R11 cleared hi");
        rd(1'b0, "R11 cleared lo");
        summary();
    end
endmodule